// File: doc/BRIEF.md
# Uncached Load Entry Controller

This block tracks the life of one uncached load held in one slot of a load queue. Once allocated, the slot waits until it may issue. A non-cacheable load may issue as soon as the slot is valid. A device (MMIO) load must wait until its instruction reaches the head of the reorder buffer. The slot then waits for its request to be taken by the outgoing holding register. After that it waits for the data response, and finally for the writeback acknowledge before it returns to the free pool. Selection between slots and bus handling live outside this block.

A pipeline redirect flushes the slot when the slot's load is younger than the redirect point. If no request is outstanding, the slot is freed at once. If a request is outstanding, the flush is parked in a sticky bit so that the response still pairs with this slot. The slot is then freed when that response arrives, and no writeback takes place. The index that the downstream buffer assigns to the request is captured from the ID response one cycle after issue.

Top module: `uc_entry_ctrl`

## Requirements
- R1: While rst_ni is low, valid_o, issue_rdy_o, wb_rdy_o and free_o are all 0.
- R2: alloc_i loads mmio and age into a free slot, and valid_o rises after the next edge. alloc_i while valid_o is 1 is ignored, and mmio_o keeps its stored value.
- R3: A non-cacheable slot (mmio flag 0) raises issue_rdy_o on the second rising edge after the allocating cycle.
- R4: An MMIO slot (mmio flag 1) stays idle while rob_head_i is 0. issue_rdy_o rises on the edge after a cycle with rob_head_i high.
- R5: issue_fire_i while issue_rdy_o is 1 moves the slot to awaiting-response, so issue_rdy_o drops on the next edge.
- R6: idresp_valid_i in the cycle right after an issue sets slave_acc_o to 1 and stores idresp_sid_i in slave_id_o. An ID response at any other time is ignored.
- R7: resp_valid_i while awaiting response raises wb_rdy_o on the next edge, and presents resp_data_i on data_o and resp_err_i on err_o.
- R8: Writeback fires on mmio_wb_i for an MMIO slot and on nc_wb_i for a non-cacheable slot. The other strobe is ignored. When writeback fires, free_o is 1 in that cycle and valid_o is 0 after the edge.
- R9: Ages are {wrap flag, index}. The slot is younger than the redirect when the flags are equal and its index is greater, or when the flags differ and its index is smaller. Only a younger slot is flushed.
- R10: A flush with no request outstanding drives free_o in the same cycle and clears valid_o on the next edge.
- R11: A flush while a request is outstanding keeps the slot valid with free_o at 0 until resp_valid_i arrives. free_o is 1 in the response cycle, and wb_rdy_o never rises.
- R12: A redirect that flushes an awaiting-response slot in the same cycle as its response frees the slot in that cycle, with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate a load into this slot |
| alloc_mmio_i | input | 1 | Load is a device (MMIO) access |
| alloc_age_i | input | AGE_W+1 | Age tag {wrap flag, index} |
| rob_head_i | input | 1 | This load's instruction is at the reorder-buffer head |
| issue_fire_i | input | 1 | Request taken by the holding register |
| idresp_valid_i | input | 1 | ID response from the downstream buffer |
| idresp_sid_i | input | SID_W | Buffer index assigned to the request |
| resp_valid_i | input | 1 | Data response for this slot |
| resp_data_i | input | DATA_W | Response data |
| resp_err_i | input | 1 | Response carries a bus error |
| mmio_wb_i | input | 1 | Writeback acknowledge, MMIO path |
| nc_wb_i | input | 1 | Writeback acknowledge, non-cacheable path |
| redirect_valid_i | input | 1 | Pipeline redirect |
| redirect_age_i | input | AGE_W+1 | Age tag of the redirect point |
| valid_o | output | 1 | Slot is occupied |
| mmio_o | output | 1 | Stored MMIO flag |
| issue_rdy_o | output | 1 | Slot is ready to issue |
| wb_rdy_o | output | 1 | Slot is ready to write back |
| free_o | output | 1 | Slot is released this cycle |
| slave_acc_o | output | 1 | Downstream buffer accepted the request |
| slave_id_o | output | SID_W | Stored buffer index |
| data_o | output | DATA_W | Stored response data |
| err_o | output | 1 | Stored exception flag |

## Verification
A redirect can coincide with two other events: with the issue capture of a ready slot, and with the data response of an outstanding slot. The bench drives both pairs in one cycle. In the first case the flush must be deferred: free_o stays low and the slot remains valid. In the second case free_o must rise in that same cycle, and wb_rdy_o must stay low afterwards. The scoreboard holds one expected result per response that should reach writeback. Any writeback seen after a flushed response is reported as unexpected.

// File: rtl/uc_entry_pkg.sv
package uc_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2,
    ST_WAIT = 2'd3
  } uc_state_e;
endpackage

// File: rtl/uc_age_cmp.sv
module uc_age_cmp #(
  parameter int AGE_W = 6
) (
  input  logic [AGE_W:0] a_i,
  input  logic [AGE_W:0] b_i,
  output logic           younger_o
);
  logic flag_eq;

  assign flag_eq   = a_i[AGE_W] == b_i[AGE_W];
  assign younger_o = flag_eq ? (a_i[AGE_W-1:0] > b_i[AGE_W-1:0])
                             : (a_i[AGE_W-1:0] < b_i[AGE_W-1:0]);
endmodule

// File: rtl/uc_flush_ctl.sv
module uc_flush_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic flush_req_i,
  input  logic in_flight_i,
  input  logic resp_i,
  output logic flush_now_o,
  output logic resp_free_o,
  output logic pend_o
);
  logic pend_q;

  assign flush_now_o = flush_req_i & ~in_flight_i;
  // response retires a parked flush, or one arriving in the same cycle
  assign resp_free_o = resp_i & (pend_q | flush_req_i);
  assign pend_o      = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pend_q <= 1'b0;
    else if (clear_i || resp_i)          pend_q <= 1'b0;
    else if (flush_req_i && in_flight_i) pend_q <= 1'b1;
  end

  AST_PEND_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && resp_i |=> !pend_q); // R11
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !resp_i && !clear_i |=> pend_q); // R11
  AST_PEND_NO_EARLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !resp_i |-> !resp_free_o); // R11
endmodule

// File: rtl/uc_entry_ctrl.sv
module uc_entry_ctrl
  import uc_entry_pkg::*;
#(
  parameter int AGE_W  = 6,
  parameter int SID_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              alloc_mmio_i,
  input  logic [AGE_W:0]    alloc_age_i,
  input  logic              rob_head_i,
  input  logic              issue_fire_i,
  input  logic              idresp_valid_i,
  input  logic [SID_W-1:0]  idresp_sid_i,
  input  logic              resp_valid_i,
  input  logic [DATA_W-1:0] resp_data_i,
  input  logic              resp_err_i,
  input  logic              mmio_wb_i,
  input  logic              nc_wb_i,
  input  logic              redirect_valid_i,
  input  logic [AGE_W:0]    redirect_age_i,
  output logic              valid_o,
  output logic              mmio_o,
  output logic              issue_rdy_o,
  output logic              wb_rdy_o,
  output logic              free_o,
  output logic              slave_acc_o,
  output logic [SID_W-1:0]  slave_id_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  localparam int AgeBits = AGE_W + 1;

  uc_state_e           state_q, state_d;
  logic                valid_q, mmio_q, err_q, sacc_q, issue_d_q;
  logic [AgeBits-1:0]  age_q;
  logic [SID_W-1:0]    sid_q;
  logic [DATA_W-1:0]   data_q;

  logic younger, flush_req, in_flight, resp_hit, wb_fire, can_send;
  logic flush_now, resp_free, release_w, do_alloc, pend;

  uc_age_cmp #(.AGE_W(AGE_W)) u_age_cmp (
    .a_i       (age_q),
    .b_i       (redirect_age_i),
    .younger_o (younger)
  );

  assign flush_req = valid_q & redirect_valid_i & younger;
  assign in_flight = (state_q == ST_RESP) | ((state_q == ST_REQ) & issue_fire_i);
  assign resp_hit  = (state_q == ST_RESP) & resp_valid_i;
  assign wb_fire   = (state_q == ST_WAIT) & (mmio_q ? mmio_wb_i : nc_wb_i);
  assign can_send  = valid_q & (~mmio_q | rob_head_i);
  assign do_alloc  = alloc_i & ~valid_q;

  uc_flush_ctl u_flush_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (do_alloc),
    .flush_req_i (flush_req),
    .in_flight_i (in_flight),
    .resp_i      (resp_hit),
    .flush_now_o (flush_now),
    .resp_free_o (resp_free),
    .pend_o      (pend)
  );

  assign release_w = flush_now | resp_free | wb_fire;

  always_comb begin
    state_d = state_q;
    if (release_w) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (can_send)     state_d = ST_REQ;
        ST_REQ:  if (issue_fire_i) state_d = ST_RESP;
        ST_RESP: if (resp_valid_i) state_d = ST_WAIT;
        ST_WAIT: state_d = ST_WAIT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      valid_q   <= 1'b0;
      mmio_q    <= 1'b0;
      age_q     <= '0;
      issue_d_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      issue_d_q <= (state_q == ST_REQ) & issue_fire_i;
      if (do_alloc) begin
        valid_q <= 1'b1;
        mmio_q  <= alloc_mmio_i;
        age_q   <= alloc_age_i;
      end else if (release_w) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sacc_q <= 1'b0;
      sid_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (do_alloc) begin
        sacc_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (issue_d_q && idresp_valid_i) begin
        sacc_q <= 1'b1;
        sid_q  <= idresp_sid_i;
      end
      if (resp_hit) begin
        data_q <= resp_data_i;
        err_q  <= resp_err_i;
      end
    end
  end

  assign valid_o     = valid_q;
  assign mmio_o      = mmio_q;
  assign issue_rdy_o = state_q == ST_REQ;
  assign wb_rdy_o    = state_q == ST_WAIT;
  assign free_o      = release_w;
  assign slave_acc_o = sacc_q;
  assign slave_id_o  = sid_q;
  assign data_o      = data_q;
  assign err_o       = err_q;

  AST_FREE_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |=> !valid_o); // R8
  AST_MMIO_WAITS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(issue_rdy_o) && mmio_o |-> $past(rob_head_i)); // R4
  AST_ISSUE_LEAVES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_rdy_o && issue_fire_i |=> !issue_rdy_o); // R5
  AST_WB_AFTER_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_rdy_o) |-> $past(resp_valid_i)); // R7
  AST_SID_FROM_IDRESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slave_acc_o) |-> $past(idresp_valid_i)); // R6
  AST_PARKED_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> !wb_rdy_o); // R11
endmodule

// File: tb/uc_entry_ctrl_bench.sv
module uc_entry_ctrl_bench;
  localparam int AGE_W = 6, SID_W = 4, DATA_W = 32;
  localparam time HALF = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_i, alloc_mmio_i, rob_head_i, issue_fire_i, idresp_valid_i;
  logic resp_valid_i, resp_err_i, mmio_wb_i, nc_wb_i, redirect_valid_i;
  logic [AGE_W:0]    alloc_age_i, redirect_age_i;
  logic [SID_W-1:0]  idresp_sid_i, slave_id_o;
  logic [DATA_W-1:0] resp_data_i, data_o;
  logic valid_o, mmio_o, issue_rdy_o, wb_rdy_o, free_o, slave_acc_o, err_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [DATA_W:0] exp_q[$];

  always #HALF clk_i = ~clk_i;

  uc_entry_ctrl #(.AGE_W(AGE_W), .SID_W(SID_W), .DATA_W(DATA_W)) u_uc_entry_ctrl (.*);

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic clr();
    alloc_i = 0; alloc_mmio_i = 0; alloc_age_i = '0; rob_head_i = 0;
    issue_fire_i = 0; idresp_valid_i = 0; idresp_sid_i = '0;
    resp_valid_i = 0; resp_data_i = '0; resp_err_i = 0;
    mmio_wb_i = 0; nc_wb_i = 0; redirect_valid_i = 0; redirect_age_i = '0;
  endtask

  task automatic do_alloc(logic mmio, logic [AGE_W:0] age);
    alloc_i = 1; alloc_mmio_i = mmio; alloc_age_i = age;
    step(); clr();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: pops an expected result on every writeback
  initial forever begin
    @(negedge clk_i); #8;
    if (rst_ni && wb_rdy_o && (mmio_o ? mmio_wb_i : nc_wb_i)) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R11 unexpected writeback act=%0h exp=none", data_o);
      end else begin
        logic [DATA_W:0] e;
        e = exp_q.pop_front();
        chk("R7 data", data_o, e[DATA_W-1:0]);
        chk("R7 err", {31'd0, err_o}, {31'd0, e[DATA_W]});
        chk("R8 free on wb", {31'd0, free_o}, 32'd1);
      end
    end
  end

  initial begin
    #(HALF * 2 * 5000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    clr();
    repeat (3) step();
    chk("R1 valid", {31'd0, valid_o}, 0);
    chk("R1 issue_rdy", {31'd0, issue_rdy_o}, 0);
    chk("R1 wb_rdy", {31'd0, wb_rdy_o}, 0);
    chk("R1 free", {31'd0, free_o}, 0);
    rst_ni = 1; step();

    // NC lifecycle
    do_alloc(0, {1'b0, 6'd5});
    chk("R2 valid", {31'd0, valid_o}, 1);
    chk("R3 still idle", {31'd0, issue_rdy_o}, 0);
    alloc_i = 1; alloc_mmio_i = 1; alloc_age_i = {1'b0, 6'd40}; step(); clr();
    chk("R3 issue_rdy", {31'd0, issue_rdy_o}, 1);
    chk("R2 alloc ignored", {31'd0, mmio_o}, 0);
    issue_fire_i = 1; step(); clr();
    chk("R5 left req", {31'd0, issue_rdy_o}, 0);
    idresp_valid_i = 1; idresp_sid_i = 4'd3; step(); clr();
    chk("R6 acc", {31'd0, slave_acc_o}, 1);
    chk("R6 sid", {28'd0, slave_id_o}, 3);
    idresp_valid_i = 1; idresp_sid_i = 4'd9; step(); clr();
    chk("R6 late idresp ignored", {28'd0, slave_id_o}, 3);
    resp_valid_i = 1; resp_data_i = 32'hA5; resp_err_i = 1;
    exp_q.push_back({1'b1, 32'hA5}); step(); clr();
    chk("R7 wb_rdy", {31'd0, wb_rdy_o}, 1);
    mmio_wb_i = 1; step(); clr();
    chk("R8 wrong strobe ignored", {31'd0, wb_rdy_o}, 1);
    nc_wb_i = 1; #5; chk("R8 free", {31'd0, free_o}, 1); step(); clr();
    chk("R8 valid cleared", {31'd0, valid_o}, 0);

    // MMIO head gating, redirect compare
    do_alloc(1, {1'b0, 6'd7});
    repeat (3) step();
    chk("R4 waits head", {31'd0, issue_rdy_o}, 0);
    rob_head_i = 1; step(); clr();
    chk("R4 issue_rdy", {31'd0, issue_rdy_o}, 1);
    redirect_valid_i = 1; redirect_age_i = {1'b0, 6'd9}; #5;
    chk("R9 older kept", {31'd0, free_o}, 0); step(); clr();
    chk("R9 still valid", {31'd0, valid_o}, 1);
    redirect_valid_i = 1; redirect_age_i = {1'b0, 6'd3}; #5;
    chk("R10 free", {31'd0, free_o}, 1); step(); clr();
    chk("R10 valid", {31'd0, valid_o}, 0);
    chk("R10 issue_rdy", {31'd0, issue_rdy_o}, 0);

    // wrapped flag
    do_alloc(0, {1'b1, 6'd2});
    redirect_valid_i = 1; redirect_age_i = {1'b0, 6'd6}; #5;
    chk("R9 wrap younger", {31'd0, free_o}, 1); step(); clr();
    chk("R9 wrap cleared", {31'd0, valid_o}, 0);

    // deferred flush: redirect together with issue capture
    do_alloc(0, {1'b0, 6'd10}); step();
    chk("R3 ready", {31'd0, issue_rdy_o}, 1);
    issue_fire_i = 1; redirect_valid_i = 1; redirect_age_i = {1'b0, 6'd4}; #5;
    chk("R11 no free in flight", {31'd0, free_o}, 0); step(); clr();
    chk("R11 held", {31'd0, valid_o}, 1);
    repeat (2) step();
    chk("R11 still held", {31'd0, valid_o}, 1);
    resp_valid_i = 1; resp_data_i = 32'h77; #5;
    chk("R11 free on resp", {31'd0, free_o}, 1); step(); clr();
    chk("R11 valid", {31'd0, valid_o}, 0);
    chk("R11 no wb", {31'd0, wb_rdy_o}, 0);

    // redirect and response in the same cycle
    do_alloc(0, {1'b0, 6'd12}); step();
    issue_fire_i = 1; step(); clr();
    redirect_valid_i = 1; redirect_age_i = {1'b0, 6'd1};
    resp_valid_i = 1; resp_data_i = 32'h55; #5;
    chk("R12 free", {31'd0, free_o}, 1); step(); clr();
    chk("R12 valid", {31'd0, valid_o}, 0);
    chk("R12 no wb", {31'd0, wb_rdy_o}, 0);

    // MMIO writeback path
    do_alloc(1, {1'b0, 6'd20});
    rob_head_i = 1; step(); clr();
    issue_fire_i = 1; step(); clr();
    resp_valid_i = 1; resp_data_i = 32'h3C; resp_err_i = 0;
    exp_q.push_back({1'b0, 32'h3C}); step(); clr();
    chk("R7 mmio wb_rdy", {31'd0, wb_rdy_o}, 1);
    nc_wb_i = 1; step(); clr();
    chk("R8 nc strobe ignored", {31'd0, wb_rdy_o}, 1);
    mmio_wb_i = 1; #5; chk("R8 mmio free", {31'd0, free_o}, 1); step(); clr();
    chk("R8 mmio valid", {31'd0, valid_o}, 0);
    chk("R7 scoreboard drained", exp_q.size(), 0);

    step();
    finish_run();
  end
endmodule